// File: doc/BRIEF.md
# Byte-to-Serial Stream Adapter

This block drains bytes from an upstream FIFO and sends them out one bit per accepted link cycle, least significant bit first. A controller sequences a byte through its bit positions. A shift register holds the byte being sent. The link side is a valid/ready stream. A bit is transferred on each rising clock edge where `ser_valid` and `ser_ready` are both high. While `ser_ready` is low, the adapter holds both the bit it presents and its position within the byte. This lets the link set the pace without losing or repeating bits.

The FIFO read side is show-ahead. `fifo_data` carries the head byte whenever `fifo_empty` is low, and a one-cycle `fifo_pop` removes that byte. The adapter captures the head byte into the shift register when it needs a new byte. It pops the FIFO during the transfer of bit 0 of that byte, so the following byte becomes the new head while the current one is still shifting. When the last bit is accepted, the next head byte is captured on the same edge, which gives gap-free streaming. If the FIFO has run dry at that point, the adapter falls back to an idle state and waits for a byte. Framing and start or stop bits belong to other blocks.

Top module: `byte_serializer`

## Requirements
- R1: During and right after synchronous reset, `ser_valid` is 0, `fifo_pop` is 0 and `ser_bit` is 0.
- R2: While idle with `fifo_empty` high, `ser_valid` stays 0 and `fifo_pop` stays 0. In the clock cycle after the first edge at which the adapter sees `fifo_empty` low, `ser_valid` is 1 and `ser_bit` equals bit 0 of `fifo_data`.
- R3: Each byte is sent as DATA_W bits in order from bit 0 up to bit DATA_W-1, one bit per edge with `ser_valid` and `ser_ready` both high.
- R4: `fifo_pop` is high only in a cycle where bit 0 of a byte is being accepted (`ser_valid` and `ser_ready` high). It pulses exactly once per byte sent.
- R5: When `ser_valid` is 1 and `ser_ready` is 0, the next cycle still has `ser_valid` at 1 and an unchanged `ser_bit`.
- R6: If `fifo_empty` is low at the edge where the last bit of a byte is accepted, `ser_valid` stays 1 in the next cycle and bit 0 of the next byte follows with no idle cycle.
- R7: If `fifo_empty` is high at the edge where the last bit of a byte is accepted, `ser_valid` is 0 in the next cycle and `fifo_pop` stays 0 until new data arrives.
- R8: Zeros are shifted into the top of the shift register, so whenever `ser_valid` is 0, `ser_bit` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| fifo_data | input | DATA_W | Head byte of the upstream FIFO (show-ahead) |
| fifo_empty | input | 1 | Upstream FIFO holds no byte |
| fifo_pop | output | 1 | Removes the head byte from the FIFO at this edge |
| ser_ready | input | 1 | Link accepts the presented bit at this edge |
| ser_valid | output | 1 | A serial bit is presented on ser_bit |
| ser_bit | output | 1 | Serial data bit, LSB of each byte first |

## Verification
On every cycle, the checker confirms the following. Pops occur only on an accepted first bit. A stalled bit stays valid and unchanged. The adapter stays idle while the FIFO is empty. A byte boundary either continues without a bubble or drops to idle, depending on `fifo_empty`. The line is low while idle. The bit order and values of the serial stream can only be shown by the bench's scenarios. So can the first-bit latency after data appears, and the match between bytes popped and bytes sent. Those scenarios replay bytes through a FIFO model under steady, stalling and irregular ready patterns, and compare every accepted bit against the expected bit sequence.

// File: rtl/byte_serializer_pkg.sv
`timescale 1ns/1ps
package byte_serializer_pkg;
  // Controller phase: waiting for a byte, or sending one.
  typedef enum logic {PH_IDLE = 1'b0, PH_SHIFT = 1'b1} phase_e;

  // Command from controller to shift register.
  typedef struct packed {
    logic load;
    logic shift;
  } sr_cmd_t;
endpackage

// File: rtl/bser_ctrl.sv
`timescale 1ns/1ps
module bser_ctrl
  import byte_serializer_pkg::*;
#(
  parameter int unsigned NBITS = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    fifo_empty,
  input  logic    ser_ready,
  output logic    fifo_pop,
  output logic    ser_valid,
  output sr_cmd_t cmd
);
  localparam int unsigned IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBITS - 1);

  phase_e phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic accept, at_last, refill;

  always_comb begin
    accept    = (phase_q == PH_SHIFT) && ser_ready;
    at_last   = (idx_q == LAST_IDX);
    refill    = !fifo_empty;
    cmd.load  = ((phase_q == PH_IDLE) && refill) || (accept && at_last && refill);
    cmd.shift = accept && !cmd.load;
    fifo_pop  = accept && (idx_q == '0);
    ser_valid = (phase_q == PH_SHIFT);

    phase_d = phase_q;
    idx_d   = idx_q;
    case (phase_q)
      PH_IDLE: begin
        if (refill) begin
          phase_d = PH_SHIFT;
          idx_d   = '0;
        end
      end
      PH_SHIFT: begin
        if (accept) begin
          if (at_last) begin
            idx_d = '0;
            if (!refill) phase_d = PH_IDLE;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end
endmodule

// File: rtl/bser_shreg.sv
`timescale 1ns/1ps
module bser_shreg
  import byte_serializer_pkg::*;
#(
  parameter int unsigned NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  sr_cmd_t          cmd,
  input  logic [NBITS-1:0] din,
  output logic             sout
);
  logic [NBITS-1:0] q, nxt;

  for (genvar i = 0; i < NBITS; i++) begin : g_cell
    logic upper;
    if (i == NBITS - 1) begin : g_top
      assign upper = 1'b0;
    end else begin : g_mid
      assign upper = q[i+1];
    end
    assign nxt[i] = cmd.load ? din[i] : (cmd.shift ? upper : q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assign sout = q[0];
endmodule

// File: rtl/byte_serializer.sv
`timescale 1ns/1ps
module byte_serializer
  import byte_serializer_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  input  logic              ser_ready,
  output logic              ser_valid,
  output logic              ser_bit
);
  sr_cmd_t cmd;

  bser_ctrl #(.NBITS(DATA_W)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .fifo_empty (fifo_empty),
    .ser_ready  (ser_ready),
    .fifo_pop   (fifo_pop),
    .ser_valid  (ser_valid),
    .cmd        (cmd)
  );

  bser_shreg #(.NBITS(DATA_W)) shreg_i (
    .clk  (clk),
    .rst  (rst),
    .cmd  (cmd),
    .din  (fifo_data),
    .sout (ser_bit)
  );
endmodule

// File: rtl/byte_serializer_chk.sv
`timescale 1ns/1ps
module byte_serializer_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic clk,
  input logic rst,
  input logic fifo_empty,
  input logic fifo_pop,
  input logic ser_ready,
  input logic ser_valid,
  input logic ser_bit
);
  localparam int unsigned CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  // Independent count of accepted bits within the current byte.
  logic [CW-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (ser_valid && ser_ready) cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
  end

  assert_pop_on_accept_R4: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> (ser_valid && ser_ready));
  assert_pop_first_bit_R4: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> (cnt == '0));
  assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (rst)
    (ser_valid && !ser_ready) |=> (ser_valid && $stable(ser_bit)));
  assert_idle_while_empty_R2: assert property (@(posedge clk) disable iff (rst)
    (!ser_valid && fifo_empty) |=> !ser_valid);
  assert_no_bubble_R6: assert property (@(posedge clk) disable iff (rst)
    (ser_valid && ser_ready && cnt == LAST && !fifo_empty) |=> ser_valid);
  assert_drain_to_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (ser_valid && ser_ready && cnt == LAST && fifo_empty) |=> !ser_valid);
  assert_low_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !ser_valid |-> !ser_bit);
endmodule

bind byte_serializer byte_serializer_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .fifo_empty (fifo_empty),
  .fifo_pop   (fifo_pop),
  .ser_ready  (ser_ready),
  .ser_valid  (ser_valid),
  .ser_bit    (ser_bit)
);

// File: tb/byte_serializer_tb_top.sv
`timescale 1ns/1ps
module byte_serializer_tb_top;
  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] fifo_data = '0;
  logic          fifo_empty = 1'b1;
  logic          fifo_pop;
  logic          ser_ready = 1'b0;
  logic          ser_valid;
  logic          ser_bit;

  always #2.5 clk = ~clk;

  byte_serializer #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .fifo_pop(fifo_pop), .ser_ready(ser_ready), .ser_valid(ser_valid), .ser_bit(ser_bit)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_pops = 0;
  int n_bytes = 0;
  int bit_pos = 0;
  logic [DW-1:0] fq[$];
  logic          exp_q[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Upstream FIFO model (show-ahead, registered flags).
  always @(posedge clk) begin
    if (!rst && fifo_pop && fq.size() > 0) void'(fq.pop_front());
    fifo_empty <= (fq.size() == 0);
    fifo_data  <= (fq.size() > 0) ? fq[0] : '0;
  end

  // Driver: queue a byte in the FIFO and its bits on the scoreboard.
  task automatic push_byte(input logic [DW-1:0] b);
    fq.push_back(b);
    n_bytes++;
    for (int i = 0; i < DW; i++) exp_q.push_back(b[i]);
  endtask

  // Monitor / scoreboard.
  logic prev_valid = 1'b0, prev_ready = 1'b0, prev_bit = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_valid && !prev_ready) begin
        chk(ser_valid == 1'b1, "R5", "stalled valid", int'(ser_valid), 1);
        chk(ser_bit == prev_bit, "R5", "stalled bit", int'(ser_bit), int'(prev_bit));
      end
      if (fifo_pop) begin
        n_pops++;
        chk(bit_pos == 0 && ser_valid && ser_ready, "R4", "pop bit position", bit_pos, 0);
      end
      if (ser_valid && ser_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected bit", int'(ser_bit), -1);
        end else begin
          logic e;
          e = exp_q.pop_front();
          chk(ser_bit == e, "R3", "serial bit", int'(ser_bit), int'(e));
        end
        bit_pos = (bit_pos + 1) % DW;
      end
      prev_valid = ser_valid;
      prev_ready = ser_ready;
      prev_bit   = ser_bit;
    end
  end

  task automatic wait_drained();
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_seq();
    logic [7:0] lfsr;
    int bad, cnt;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(ser_valid == 1'b0, "R1", "valid in reset", int'(ser_valid), 0);
    chk(fifo_pop == 1'b0, "R1", "pop in reset", int'(fifo_pop), 0);
    @(posedge clk); #1 rst = 1'b0; ser_ready = 1'b1;
    @(negedge clk);
    chk(ser_valid == 1'b0, "R1", "valid after reset", int'(ser_valid), 0);
    chk(ser_bit == 1'b0, "R1", "bit after reset", int'(ser_bit), 0);

    bad = 0;
    repeat (6) begin
      @(negedge clk);
      if (ser_valid || fifo_pop) bad++;
    end
    chk(bad == 0, "R2", "idle cycles with activity", bad, 0);

    // First-bit latency.
    @(posedge clk); #1 push_byte(8'hA5);
    @(negedge clk);
    @(negedge clk);
    chk(ser_valid == 1'b0, "R2", "valid before load", int'(ser_valid), 0);
    @(negedge clk);
    chk(ser_valid == 1'b1, "R2", "valid after load", int'(ser_valid), 1);
    chk(ser_bit == 1'b1, "R2", "first bit", int'(ser_bit), 1);
    wait_drained();

    // Back-to-back bytes then drain to idle.
    @(posedge clk); #1 begin push_byte(8'h3C); push_byte(8'h81); push_byte(8'hF0); end
    for (int i = 0; i < 10 && !ser_valid; i++) @(negedge clk);
    cnt = ser_valid ? 1 : 0;
    repeat (3*DW - 1) begin
      @(negedge clk);
      if (ser_valid) cnt++;
    end
    chk(cnt == 3*DW, "R6", "valid cycles over three bytes", cnt, 3*DW);
    @(negedge clk);
    chk(ser_valid == 1'b0, "R7", "valid after drain", int'(ser_valid), 0);
    chk(fifo_pop == 1'b0, "R7", "pop after drain", int'(fifo_pop), 0);
    chk(ser_bit == 1'b0, "R8", "bit while idle", int'(ser_bit), 0);
    repeat (3) @(negedge clk);
    chk(ser_valid == 1'b0 && fifo_pop == 1'b0, "R7", "still idle", int'(ser_valid), 0);

    // Irregular ready with bytes arriving mid-stream.
    lfsr = 8'h5B;
    @(posedge clk); #1 begin push_byte(8'h01); push_byte(8'h80); push_byte(8'h6E); push_byte(8'h00); end
    for (int c = 0; c < 300; c++) begin
      @(posedge clk); #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ser_ready = lfsr[0] | lfsr[2];
      if (c == 37) push_byte(8'hD2);
      if (c == 120) begin push_byte(8'hFF); push_byte(8'h49); end
    end
    // Long stall.
    @(posedge clk); #1 begin ser_ready = 1'b0; push_byte(8'h96); end
    repeat (12) @(posedge clk);
    #1 ser_ready = 1'b1;
    wait_drained();
    chk(exp_q.size() == 0, "R3", "bits left unsent", exp_q.size(), 0);
    chk(n_pops == n_bytes, "R4", "pops per byte", n_pops, n_bytes);
    chk(ser_valid == 1'b0 && ser_bit == 1'b0, "R8", "idle line low", int'(ser_bit), 0);
  endtask

  initial begin
    fork
      run_seq();
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule